// File: doc/BRIEF.md
# Shared interrupt request router

This block takes eight level-sensitive shared interrupt request inputs and one ACPI system control interrupt (SCI) input. It drives a 24-wide vector of global interrupt lines. Lines 0 to 15 go to a legacy interrupt controller and lines 16 to 23 go to an I/O APIC. Every request input drives two paths at the same time. The first is a fixed APIC line, 16 plus the input index, which no other input shares. The second is a programmable legacy line, which any number of inputs may share.

A small register write port holds eight route registers, one per request input, and one control register. The control register places the SCI on one of five global lines. When the SCI placement changes while the SCI is high, the SCI is held off all lines for exactly one output cycle. It then appears on the new line, so an edge-sensitive consumer sees a fresh assertion. All outputs are registered and follow their inputs and registers one clock later.

Top module: `irq_router`

## Requirements
- R1: While reset is low, every output line is 0. Reset sets every route register to 0x80 (legacy path disabled) and the control register to 0x00, which places the SCI on line 9.
- R2: Output line 16+n equals request input n from one clock earlier, ORed with the SCI when the SCI is placed on that line.
- R3: When bit 7 of route register n is 1, request input n drives no legacy line.
- R4: A legacy line L (0 to 15) is the OR of every request input whose route register has bit 7 = 0 and bits [6:0] = L. Inputs may share a line.
- R5: A route register with bit 7 = 0 and a bits [6:0] value of 16 or more drives no output line from its legacy path.
- R6: Control register bits [2:0] place the SCI: 0 selects line 9, 1 line 10, 2 line 11, 4 line 20 and 5 line 21. Codes 3, 6 and 7 leave the SCI on no line. Bits [7:3] have no effect.
- R7: The SCI level is ORed into its selected line, together with any request input that maps to that line.
- R8: A control write that changes the selected SCI line while the SCI input is high yields one output cycle in which the SCI is on no line. The SCI appears on the new line in the following cycle.
- R9: A control write that keeps the same SCI line produces no gap in the SCI output.
- R10: Register writes to the address map place route register n at address n (0 to 7) and the control register at address 8. A write takes effect on the output one cycle after the write edge. Writes to addresses 9 to 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pirq_in | input | 8 | Shared interrupt request levels |
| sci_in | input | 1 | ACPI system control interrupt level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| gsi_out | output | 24 | Registered global interrupt line levels |

## Verification
Random request patterns run against random route registers whose legacy numbers span both the valid range and values of 16 and above. These patterns separate correct line sharing from one-to-one mapping, and separate unroutable numbers from wrap-around into the APIC range. Directed sequences step the SCI through every control code with the SCI held high, which exposes each line decode and the reserved codes. Changing and same-line control writes under a high SCI distinguish a correct single gap cycle from both a missing gap and a spurious one. Writes to unmapped addresses show whether any register is aliased.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int ROUTE_W   = 8;
  localparam int ROUTE_DIS = 7;
  localparam int ROUTE_NUM_W = 7;

  typedef struct packed {
    logic       vld;
    logic [7:0] line;
  } sci_sel_t;

  function automatic sci_sel_t sci_decode(input logic [2:0] code);
    sci_sel_t s;
    s.vld  = 1'b1;
    s.line = 8'd0;
    unique case (code)
      3'd0: s.line = 8'd9;
      3'd1: s.line = 8'd10;
      3'd2: s.line = 8'd11;
      3'd4: s.line = 8'd20;
      3'd5: s.line = 8'd21;
      default: s.vld = 1'b0;
    endcase
    return s;
  endfunction

  function automatic logic route_active(input logic [ROUTE_W-1:0] r, input int num_legacy);
    return !r[ROUTE_DIS] && (int'(r[ROUTE_NUM_W-1:0]) < num_legacy);
  endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs #(
  parameter int NUM_PIRQ = 8,
  parameter int ADDR_W   = 4,
  parameter logic [7:0] ROUTE_RST = 8'h80,
  parameter logic [7:0] CTRL_RST  = 8'h00
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [7:0]                wr_data,
  output logic [NUM_PIRQ-1:0][7:0]  route_q,
  output logic [7:0]                ctrl_q,
  output logic                      ctrl_we
);
  localparam int CTRL_ADDR = NUM_PIRQ;

  assign ctrl_we = wr_en && (int'(wr_addr) == CTRL_ADDR);

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                route_q[n] <= ROUTE_RST;
      else if (wr_en && int'(wr_addr) == n)      route_q[n] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_we) ctrl_q <= wr_data;
  end
endmodule

// File: rtl/irq_router_legacy_map.sv
module irq_router_legacy_map
  import irq_router_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int NUM_LEGACY = 16
) (
  input  logic [NUM_PIRQ-1:0]                  pirq_in,
  input  logic [NUM_PIRQ-1:0][7:0]             route_q,
  output logic [NUM_PIRQ-1:0][NUM_LEGACY-1:0]  route_hit,
  output logic [NUM_LEGACY-1:0]                legacy_lvl
);
  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_hit
    always_comb begin
      route_hit[n] = '0;
      if (route_active(route_q[n], NUM_LEGACY))
        route_hit[n][route_q[n][ROUTE_NUM_W-1:0]] = 1'b1;
    end
  end

  always_comb begin
    legacy_lvl = '0;
    for (int n = 0; n < NUM_PIRQ; n++)
      if (pirq_in[n]) legacy_lvl |= route_hit[n];
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int NUM_LEGACY = 16,
  parameter int ADDR_W     = 4,
  parameter int NUM_LINES  = NUM_LEGACY + NUM_PIRQ
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PIRQ-1:0]   pirq_in,
  input  logic                  sci_in,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NUM_LINES-1:0]  gsi_out
);
  logic [NUM_PIRQ-1:0][7:0]            route_q;
  logic [7:0]                          ctrl_q;
  logic                                ctrl_we;
  logic [NUM_PIRQ-1:0][NUM_LEGACY-1:0] route_hit;
  logic [NUM_LEGACY-1:0]               legacy_lvl;
  logic [NUM_LINES-1:0]                sci_hit;
  logic                                sci_blank;
  logic                                sel_changing;
  sci_sel_t                            sel_cur, sel_new;

  irq_router_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .route_q(route_q), .ctrl_q(ctrl_q), .ctrl_we(ctrl_we)
  );

  irq_router_legacy_map #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY)) u_map (
    .pirq_in(pirq_in), .route_q(route_q),
    .route_hit(route_hit), .legacy_lvl(legacy_lvl)
  );

  // SCI placement, current and pending
  assign sel_cur      = sci_decode(ctrl_q[2:0]);
  assign sel_new      = sci_decode(wr_data[2:0]);
  assign sel_changing = ctrl_we && (sel_cur != sel_new);

  always_comb begin
    sci_hit = '0;
    if (sci_in && !sci_blank && sel_cur.vld && int'(sel_cur.line) < NUM_LINES)
      sci_hit[sel_cur.line] = 1'b1;
  end

  // one-cycle gap so the SCI reasserts on its new line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sci_blank <= 1'b0;
    else        sci_blank <= sel_changing && sci_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gsi_out <= '0;
    else        gsi_out <= {pirq_in, legacy_lvl} | sci_hit;
  end
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
  parameter int NUM_PIRQ   = 8,
  parameter int NUM_LEGACY = 16,
  parameter int NUM_LINES  = NUM_LEGACY + NUM_PIRQ
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [NUM_PIRQ-1:0]                 pirq_in,
  input logic                                sci_in,
  input logic                                wr_en,
  input logic [NUM_LINES-1:0]                gsi_out,
  input logic [NUM_PIRQ-1:0][7:0]            route_q,
  input logic [NUM_PIRQ-1:0][NUM_LEGACY-1:0] route_hit,
  input logic [NUM_LINES-1:0]                sci_hit,
  input logic                                sci_blank
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_apic_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((gsi_out[NUM_LINES-1:NUM_LEGACY] & $past(pirq_in)) == $past(pirq_in)));

  p_sci_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sci_hit));

  p_blank_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sci_blank) |-> ($past(sci_in) && $past(wr_en)));

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
    p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(route_hit[n]));
    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      route_q[n][7] |-> (route_hit[n] == '0));
    p_out_of_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(route_q[n][6:0]) >= NUM_LEGACY) |-> (route_hit[n] == '0));
  end
endmodule

bind irq_router irq_router_checker #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY)) u_chk (
  .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in), .wr_en(wr_en),
  .gsi_out(gsi_out), .route_q(route_q), .route_hit(route_hit),
  .sci_hit(sci_hit), .sci_blank(sci_blank)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pirq_in = '0;
  logic        sci_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [23:0] gsi_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [7:0] m_route [8];
  logic [7:0] m_ctrl;
  logic       m_gap;

  irq_router uut (
    .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .gsi_out(gsi_out)
  );

  always #5 clk = ~clk;

  function automatic int sci_line(input logic [7:0] c);
    case (c & 8'h07)
      8'h00: return 9;
      8'h01: return 10;
      8'h02: return 11;
      8'h04: return 20;
      8'h05: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [23:0] expect_lines(input logic [7:0] p, input logic s);
    logic [23:0] e = '0;
    for (int n = 0; n < 8; n++) begin
      if (p[n]) begin
        e[16+n] = 1'b1;
        if (m_route[n] < 8'd16) e[m_route[n][3:0]] = 1'b1;
      end
    end
    if (s && !m_gap && sci_line(m_ctrl) >= 0) e[sci_line(m_ctrl)] = 1'b1;
    return e;
  endfunction

  task automatic compare(input logic [23:0] exp_v, input string tag);
    checks++;
    if (gsi_out !== exp_v) begin
      fails++;
      $display("FAIL %s: gsi_out=%h expected=%h", tag, gsi_out, exp_v);
    end
  endtask

  // called at a negedge; applies inputs for one clock and checks the result
  task automatic step(input logic [7:0] p, input logic s, input logic we,
                      input logic [3:0] a, input logic [7:0] d, input string tag);
    logic [23:0] e;
    pirq_in = p; sci_in = s; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    e = expect_lines(p, s);
    m_gap = we && a == 4'd8 && s && (sci_line(d) != sci_line(m_ctrl));
    if (we && a < 4'd8) m_route[a[2:0]] = d;
    if (we && a == 4'd8) m_ctrl = d;
    @(negedge clk);
    wr_en = 1'b0;
    compare(e, tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int n = 0; n < 8; n++) m_route[n] = 8'h80;
    m_ctrl = 8'h00;
    m_gap  = 1'b0;

    repeat (3) @(negedge clk);
    pirq_in = 8'hFF; sci_in = 1'b1;
    @(negedge clk);
    compare(24'h0, "R1 outputs low in reset");
    pirq_in = '0; sci_in = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1: defaults - SCI on line 9, legacy paths off
    step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R1 SCI default line 9");
    step(8'hFF, 1'b0, 1'b0, 4'd0, 8'h00, "R1 default routes disabled");

    // R3: disable bit ignores the number
    step(8'h00, 1'b0, 1'b1, 4'd0, 8'h85, "R10 write route0");
    step(8'h01, 1'b0, 1'b0, 4'd0, 8'h00, "R3 disabled route drives no legacy line");

    // R4: sharing
    step(8'h00, 1'b0, 1'b1, 4'd1, 8'h03, "R10 write route1");
    step(8'h00, 1'b0, 1'b1, 4'd2, 8'h03, "R10 write route2");
    step(8'h02, 1'b0, 1'b0, 4'd0, 8'h00, "R4 shared line from pirq1");
    step(8'h06, 1'b0, 1'b0, 4'd0, 8'h00, "R4 shared line from both");
    step(8'h04, 1'b0, 1'b0, 4'd0, 8'h00, "R4 shared line from pirq2");

    // R5: number 18 is unroutable, must not leak to line 18
    step(8'h00, 1'b0, 1'b1, 4'd3, 8'h12, "R10 write route3");
    step(8'h08, 1'b0, 1'b0, 4'd0, 8'h00, "R5 route number 18 unroutable");

    // R7: SCI merged with a pirq on line 9
    step(8'h00, 1'b0, 1'b1, 4'd4, 8'h09, "R10 write route4");
    step(8'h10, 1'b1, 1'b0, 4'd0, 8'h00, "R7 SCI with pirq on line 9");
    step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R7 SCI alone on line 9");

    // R6: all codes, SCI low during writes, upper bits set
    for (int c = 0; c < 8; c++) begin
      step(8'h00, 1'b0, 1'b1, 4'd8, 8'hF8 | 8'(c), "R6 write control");
      step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R6 SCI line for code");
      step(8'h00, 1'b0, 1'b0, 4'd0, 8'h00, "R6 SCI released");
    end

    // R8: change 9 -> 10 with SCI high
    step(8'h00, 1'b0, 1'b1, 4'd8, 8'h00, "R6 control back to 9");
    step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R8 SCI on old line");
    step(8'h00, 1'b1, 1'b1, 4'd8, 8'h01, "R8 change edge keeps old line");
    step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R8 gap cycle");
    step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R8 SCI on new line 10");
    // change into the APIC range
    step(8'h00, 1'b1, 1'b1, 4'd8, 8'h05, "R8 change to 21");
    step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R8 gap before 21");
    step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R2 R8 SCI on APIC line 21");

    // R9: same line rewritten (different upper bits)
    step(8'h00, 1'b1, 1'b1, 4'd8, 8'h45, "R9 same selection write");
    step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R9 no gap on same selection");

    // R10: unmapped addresses ignored
    for (int a = 9; a < 16; a++)
      step(8'h00, 1'b0, 1'b1, 4'(a), 8'h00, "R10 unmapped write");
    step(8'hFF, 1'b1, 1'b0, 4'd0, 8'h00, "R10 state after unmapped writes");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [3:0] a;
      logic [7:0] d;
      we = ($urandom % 4) == 0;
      a  = 4'($urandom % 10);
      if (a < 4'd8) d = {1'($urandom % 4 == 0), 7'($urandom % 20)};
      else          d = 8'($urandom);
      step(8'($urandom), 1'($urandom % 3 == 0), we, a, d, "R2 R4 R7 R8 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule